// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard-resolution control for a five-stage integer pipeline with 32 general registers. It looks at the instruction sitting in decode, finds which source registers it reads and which register it will write. It compares those sources against the destinations of the two older instructions now in execute and in memory access. From that comparison it works out where each ALU operand of the decoding instruction must come from once that instruction reaches execute. The select is registered, so it is presented while the instruction is in execute.

A load whose result is needed by the very next instruction cannot be covered by forwarding. The unit then raises a stall for exactly one cycle. The pipeline holds the program counter and the fetch/decode register, and it sends an invalid bubble into execute. On the following cycle the load has moved on and its data is forwarded. A taken branch resolves in memory access and raises a flush. The flush squashes the three younger instructions and overrides any stall in the same cycle.

Top module: `fwd_interlock_unit`

## Requirements
- R1: Instruction fields are taken with bit 31 as the most significant bit: opcode [31:26], source A [25:21], source B [20:16], register-register destination [15:11]. Register-register (opcode 6'h00) and store (opcode bits [31:29]=3'b101) read A and B. Immediate ALU (bits [31:29]=3'b001), load (bits [31:29]=3'b100) and branch (bits [31:29]=3'b000, opcode non-zero) read A only. Other opcodes read nothing.
- R2: `id_dest_o` is [15:11] for register-register, [20:16] for immediate ALU and load, and 0 otherwise. `id_wr_o` is high only for those three classes with `id_valid_i` high. `id_load_o` marks a valid load.
- R3: The operand selects encode 0 = register file, 1 = execute/memory result, 2 = memory/writeback result. They are registered and change on the clock edge that moves the decoding instruction into execute.
- R4: `stall_o` is high in the same cycle when a valid decoding instruction reads a register that a valid, writing load in execute will write. Otherwise it is low.
- R5: When both older instructions write a register that is read, the one in execute (younger) wins and the select becomes 1.
- R6: After a stall cycle, both selects are 0 for the bubble that enters execute.
- R7: Register 0 is never forwarded and never causes a stall. Producers with valid or write-enable low are ignored.
- R8: `flush_o` follows a taken branch in memory access in the same cycle. Both selects are 0 after the flush edge.
- R9: A flush suppresses a stall raised in the same cycle.
- R10: While reset is asserted, both selects are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_instr_i | input | 32 | Instruction in decode |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| ex_dest_i | input | 5 | Destination of instruction in execute |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_valid_i | input | 1 | Execute slot valid |
| mem_dest_i | input | 5 | Destination of instruction in memory access |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_valid_i | input | 1 | Memory-access slot valid |
| mem_br_taken_i | input | 1 | Branch in memory access is taken |
| id_dest_o | output | 5 | Decoded destination register |
| id_wr_o | output | 1 | Decoded instruction writes a register |
| id_load_o | output | 1 | Decoded instruction is a load |
| fwd_a_o | output | 2 | Operand A source for instruction in execute |
| fwd_b_o | output | 2 | Operand B source for instruction in execute |
| stall_o | output | 1 | Hold PC and fetch/decode, bubble into execute |
| flush_o | output | 1 | Squash the three younger instructions |

## Verification
The load-use interlock and the branch flush can both fire in one cycle. The bench provokes this by presenting a taken branch while a load in execute feeds the decoding instruction. It judges that `stall_o` stays low, `flush_o` is high, and both selects read 0 after the edge. A second overlap is forwarding from both older stages at once. That case is judged by the select pointing at the execute producer.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_sel_e;

  localparam logic [5:0] OPC_RR = 6'h00;
  localparam logic [2:0] GRP_BR = 3'b000;
  localparam logic [2:0] GRP_RI = 3'b001;
  localparam logic [2:0] GRP_LD = 3'b100;
  localparam logic [2:0] GRP_ST = 3'b101;
endpackage

// File: rtl/hz_decode.sv
module hz_decode #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic [IW-1:0] instr_i,
  input  logic          valid_i,
  output logic [RW-1:0] src_a_o,
  output logic [RW-1:0] src_b_o,
  output logic          rd_a_o,
  output logic          rd_b_o,
  output logic [RW-1:0] dest_o,
  output logic          wr_o,
  output logic          load_o
);
  import hz_pkg::*;
  localparam int OPW   = 6;
  localparam int A_LSB = IW - OPW - RW;
  localparam int B_LSB = A_LSB - RW;
  localparam int D_LSB = B_LSB - RW;

  logic [OPW-1:0] opc;
  logic is_rr, is_ri, is_ld, is_st, is_br;

  assign opc     = instr_i[IW-1 -: OPW];
  assign src_a_o = instr_i[A_LSB +: RW];
  assign src_b_o = instr_i[B_LSB +: RW];

  always_comb begin
    is_rr = (opc == OPC_RR);
    is_ri = (opc[OPW-1 -: 3] == GRP_RI);
    is_ld = (opc[OPW-1 -: 3] == GRP_LD);
    is_st = (opc[OPW-1 -: 3] == GRP_ST);
    is_br = (opc[OPW-1 -: 3] == GRP_BR) && !is_rr;
  end

  always_comb begin
    rd_a_o = is_rr | is_ri | is_ld | is_st | is_br;
    rd_b_o = is_rr | is_st;
    if (is_rr)              dest_o = instr_i[D_LSB +: RW];
    else if (is_ri | is_ld) dest_o = instr_i[B_LSB +: RW];
    else                    dest_o = '0;
    wr_o   = valid_i & (is_rr | is_ri | is_ld);
    load_o = valid_i & is_ld;
  end
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel #(
  parameter int RW = 5
) (
  input  logic [RW-1:0]     src_i,
  input  logic              rd_i,
  input  logic              id_valid_i,
  input  logic [RW-1:0]     ex_dest_i,
  input  logic              ex_wr_i,
  input  logic              ex_load_i,
  input  logic              ex_valid_i,
  input  logic [RW-1:0]     mem_dest_i,
  input  logic              mem_wr_i,
  input  logic              mem_valid_i,
  output hz_pkg::src_sel_e  sel_o,
  output logic              load_hit_o
);
  import hz_pkg::*;
  logic live, ex_hit, mem_hit;

  always_comb begin
    live    = id_valid_i & rd_i & (src_i != '0);
    ex_hit  = live & ex_valid_i & ex_wr_i & (ex_dest_i == src_i);
    mem_hit = live & mem_valid_i & mem_wr_i & (mem_dest_i == src_i);
    // younger producer first
    if (ex_hit)       sel_o = SRC_EXMEM;
    else if (mem_hit) sel_o = SRC_MEMWB;
    else              sel_o = SRC_RF;
    load_hit_o = ex_hit & ex_load_i;
  end
endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  hz_pkg::src_sel_e d_i,
  output hz_pkg::src_sel_e q_o
);
  import hz_pkg::*;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= SRC_RF;
    else if (clr_i) q_o <= SRC_RF;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit #(
  parameter int NREG = 32,
  parameter int IW   = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] id_instr_i,
  input  logic          id_valid_i,
  input  logic [RW-1:0] ex_dest_i,
  input  logic          ex_wr_i,
  input  logic          ex_load_i,
  input  logic          ex_valid_i,
  input  logic [RW-1:0] mem_dest_i,
  input  logic          mem_wr_i,
  input  logic          mem_valid_i,
  input  logic          mem_br_taken_i,
  output logic [RW-1:0] id_dest_o,
  output logic          id_wr_o,
  output logic          id_load_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          flush_o
);
  import hz_pkg::*;
  localparam int NOPS = 2;

  logic [RW-1:0] src   [NOPS];
  logic          rd    [NOPS];
  src_sel_e      sel_d [NOPS];
  src_sel_e      sel_q [NOPS];
  logic [NOPS-1:0] load_hit;
  logic          bubble;

  hz_decode #(.IW(IW), .RW(RW)) u_dec (
    .instr_i (id_instr_i),
    .valid_i (id_valid_i),
    .src_a_o (src[0]),
    .src_b_o (src[1]),
    .rd_a_o  (rd[0]),
    .rd_b_o  (rd[1]),
    .dest_o  (id_dest_o),
    .wr_o    (id_wr_o),
    .load_o  (id_load_o)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_operand_sel #(.RW(RW)) u_sel (
      .src_i       (src[g]),
      .rd_i        (rd[g]),
      .id_valid_i  (id_valid_i),
      .ex_dest_i   (ex_dest_i),
      .ex_wr_i     (ex_wr_i),
      .ex_load_i   (ex_load_i),
      .ex_valid_i  (ex_valid_i),
      .mem_dest_i  (mem_dest_i),
      .mem_wr_i    (mem_wr_i),
      .mem_valid_i (mem_valid_i),
      .sel_o       (sel_d[g]),
      .load_hit_o  (load_hit[g])
    );

    hz_sel_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (bubble),
      .d_i    (sel_d[g]),
      .q_o    (sel_q[g])
    );
  end

  always_comb begin
    flush_o = mem_br_taken_i;
    stall_o = (|load_hit) & ~flush_o;  // flush wins
    bubble  = stall_o | flush_o;
    fwd_a_o = sel_q[0];
    fwd_b_o = sel_q[1];
  end
endmodule

// File: rtl/hz_checker.sv
module hz_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       id_valid_i,
  input logic [4:0] ex_dest_i,
  input logic       ex_load_i,
  input logic       ex_valid_i,
  input logic       stall_o,
  input logic       flush_o,
  input logic [1:0] fwd_a_o,
  input logic [1:0] fwd_b_o
);
  AST_FLUSH_BEATS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !stall_o); // R9
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_valid_i && ex_load_i && id_valid_i)); // R4
  AST_NO_R0_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dest_i == 5'd0) |-> !stall_o); // R7
  AST_BUBBLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o || flush_o) |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0)); // R6
  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'd3) && (fwd_b_o != 2'd3)); // R3
endmodule

bind fwd_interlock_unit hz_checker u_hz_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_valid_i (id_valid_i),
  .ex_dest_i  (ex_dest_i),
  .ex_load_i  (ex_load_i),
  .ex_valid_i (ex_valid_i),
  .stall_o    (stall_o),
  .flush_o    (flush_o),
  .fwd_a_o    (fwd_a_o),
  .fwd_b_o    (fwd_b_o)
);

// File: tb/tb_fwd_interlock_unit.sv
module tb_fwd_interlock_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] RR = 6'h00, RI = 6'h08, LD = 6'h20, ST = 6'h28, BR = 6'h04;

  logic clk = 0, rst_ni = 0;
  logic [31:0] id_instr_i = '0;
  logic id_valid_i = 0, ex_wr_i = 0, ex_load_i = 0, ex_valid_i = 0;
  logic mem_wr_i = 0, mem_valid_i = 0, mem_br_taken_i = 0;
  logic [4:0] ex_dest_i = '0, mem_dest_i = '0;
  logic [4:0] id_dest_o;
  logic id_wr_o, id_load_o, stall_o, flush_o;
  logic [1:0] fwd_a_o, fwd_b_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_interlock_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .id_instr_i(id_instr_i), .id_valid_i(id_valid_i),
    .ex_dest_i(ex_dest_i), .ex_wr_i(ex_wr_i), .ex_load_i(ex_load_i), .ex_valid_i(ex_valid_i),
    .mem_dest_i(mem_dest_i), .mem_wr_i(mem_wr_i), .mem_valid_i(mem_valid_i),
    .mem_br_taken_i(mem_br_taken_i), .id_dest_o(id_dest_o), .id_wr_o(id_wr_o),
    .id_load_o(id_load_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o),
    .stall_o(stall_o), .flush_o(flush_o)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] d);
    return {op, a, b, d, 11'b0};
  endfunction

  typedef struct packed {
    logic [31:0] instr; logic idv;
    logic [4:0] exd; logic exwr, exld, exv;
    logic [4:0] memd; logic memwr, memv, br;
    logic e_stall, e_flush; logic [4:0] e_dest; logic e_wr, e_ld;
    logic [1:0] e_fa, e_fb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{mk(RR,1,2,3),  1, 0,0,0,0, 0,0,0, 0, 0,0, 3,1,0, 0,0}, // R1 R2 plain
    '{mk(RR,1,2,3),  1, 1,1,0,1, 0,0,0, 0, 0,0, 3,1,0, 1,0}, // R3 ex fwd A
    '{mk(RR,1,2,3),  1, 0,0,0,0, 2,1,1, 0, 0,0, 3,1,0, 0,2}, // R3 mem fwd B
    '{mk(RR,4,5,3),  1, 4,1,0,1, 4,1,1, 0, 0,0, 3,1,0, 1,0}, // R5 younger wins
    '{mk(RI,5,6,0),  1, 6,1,0,1, 0,0,0, 0, 0,0, 6,1,0, 0,0}, // R2 R1 imm B unread
    '{mk(LD,7,8,0),  1, 7,1,1,1, 0,0,0, 0, 1,0, 8,1,1, 0,0}, // R4 load-use
    '{mk(LD,7,8,0),  1, 0,0,0,0, 7,1,1, 0, 0,0, 8,1,1, 2,0}, // R4 after bubble
    '{mk(RR,10,11,12),1, 9,1,1,1, 0,0,0, 0, 0,0, 12,1,0, 0,0}, // R4 no match
    '{mk(RR,0,0,3),  1, 0,1,1,1, 0,0,0, 0, 0,0, 3,1,0, 0,0}, // R7 r0 load
    '{mk(RR,0,2,3),  1, 0,0,0,0, 0,1,1, 0, 0,0, 3,1,0, 0,0}, // R7 r0 mem
    '{mk(RR,1,2,3),  1, 1,1,1,1, 0,0,0, 1, 0,1, 3,1,0, 0,0}, // R8 R9 flush+load-use
    '{mk(RR,1,2,3),  0, 1,1,1,1, 0,0,0, 0, 0,0, 3,0,0, 0,0}, // R4 id invalid
    '{mk(ST,1,2,0),  1, 2,1,1,1, 0,0,0, 0, 1,0, 0,0,0, 0,0}, // R4 store data B
    '{mk(RI,1,9,0),  1, 9,1,1,1, 0,0,0, 0, 0,0, 9,1,0, 0,0}, // R4 R2 imm B not read
    '{mk(BR,3,0,0),  1, 3,0,1,1, 3,1,1, 0, 0,0, 0,0,0, 2,0}, // R7 R1 ex no-write
    '{mk(RR,1,2,3),  1, 1,1,1,0, 2,1,0, 0, 0,0, 3,1,0, 0,0}  // R7 invalid producers
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_instr_i = v.instr; id_valid_i = v.idv;
    ex_dest_i = v.exd; ex_wr_i = v.exwr; ex_load_i = v.exld; ex_valid_i = v.exv;
    mem_dest_i = v.memd; mem_wr_i = v.memwr; mem_valid_i = v.memv; mem_br_taken_i = v.br;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: forwarding condition present while in reset
    @(negedge clk);
    drive(TBL[1]);
    @(posedge clk); #1;
    chk("R10 fwd_a in reset", fwd_a_o, 0);
    @(negedge clk); rst_ni = 1;
    drive('0);
    @(posedge clk); #1;
    chk("R10 fwd_a after reset", fwd_a_o, 0);
    chk("R10 fwd_b after reset", fwd_b_o, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      chk($sformatf("R4 stall v%0d", i), stall_o, TBL[i].e_stall);
      chk($sformatf("R8 flush v%0d", i), flush_o, TBL[i].e_flush);
      chk($sformatf("R2 dest v%0d", i), id_dest_o, TBL[i].e_dest);
      chk($sformatf("R2 wr v%0d", i), id_wr_o, TBL[i].e_wr);
      chk($sformatf("R2 load v%0d", i), id_load_o, TBL[i].e_ld);
      @(posedge clk); #1;
      chk($sformatf("R3 fwd_a v%0d", i), fwd_a_o, TBL[i].e_fa);
      chk($sformatf("R3 fwd_b v%0d", i), fwd_b_o, TBL[i].e_fb);
    end

    // R6: forwarding set up, then a stall cycle must leave a clean bubble
    @(negedge clk); drive(TBL[1]);
    @(posedge clk); #1;
    chk("R3 fwd_a set before stall", fwd_a_o, 1);
    @(negedge clk); drive(TBL[5]);
    @(posedge clk); #1;
    chk("R6 bubble fwd_a", fwd_a_o, 0);
    chk("R6 bubble fwd_b", fwd_b_o, 0);

    // R8: flush alone clears a live select
    @(negedge clk); drive(TBL[2]);
    @(posedge clk); #1;
    chk("R3 fwd_b set before flush", fwd_b_o, 2);
    @(negedge clk); drive(TBL[2]); mem_br_taken_i = 1;
    #1 chk("R8 flush raised", flush_o, 1);
    @(posedge clk); #1;
    chk("R8 flushed fwd_b", fwd_b_o, 0);

    // R9: load-use on operand B with taken branch
    @(negedge clk); drive(TBL[12]); mem_br_taken_i = 1;
    #1 chk("R9 stall suppressed", stall_o, 0);
    @(negedge clk); drive('0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule